// File: doc/BRIEF.md
# Pixel Word Unpacker and Bus Formatter

This block sits between a pixel FIFO carrying 32-bit memory words and the data pins of an LCD panel. It receives one word at a time over a valid/ready handshake. It splits the word into the pixels or byte beats it holds, and it presents one formatted pixel per accepted output beat on a 24-bit output bus. Only the low bits that the selected panel bus width uses can be non-zero.

Two source layouts are handled. In the first, two RGB565 half-words are packed per word. In the second, each word carries one 24-bit colour, and the top byte is ignored. A four-bit byte-valid mask states which bytes of the word carry real data. A reduction flag turns 8-bit colour lanes into 6-bit lanes for an 18-bit panel. The word-length code, bus-width code, mask and reduction flag are static settings. They may only change while the block holds no word. A synchronous FIFO-clear input throws away the word in flight.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset no word is held: `outValid` is 0 and, for a supported setting, `inReady` is 1.
- R2: With word-length code 0 (16-bit pixels) and bus code 0 (16-bit bus), half-word k (bits 16k+15..16k) is sent only if mask bits 2k and 2k+1 are both set. The low half-word goes before the high one. It appears on `outData[15:0]` with bits 23:16 zero.
- R3: With word-length code 0 and bus code 1 (8-bit bus), each byte i whose mask bit i is set is sent as its own beat on `outData[7:0]`, in ascending byte order, with bits 23:8 zero.
- R4: An RGB565 half-word holds red in 15:11, green in 10:5 and blue in 4:0. On bus code 2 (18-bit), the output is red,0 in 17:12, green in 11:6 and blue,0 in 5:0, with 23:18 zero. On bus code 3 (24-bit), red,000 is in 23:16, green,00 in 15:8 and blue,000 in 7:0.
- R5: With word-length code 3 (32-bit words), each word gives exactly one pixel. Bits 31:24 are ignored. Byte i (i = 0..2) reads as zero when mask bit i is clear. On bus code 3 the 24 bits are sent unchanged.
- R6: With word-length code 3 and the reduction flag set, the output is bits 21:16, 13:8 and 5:0 of the word, placed at 17:12, 11:6 and 5:0, with 23:18 zero. Output bits above the bus width are always zero: 16 bits for code 0 and 18 bits for code 2.
- R7: Word-length codes 1 and 2, and word-length code 3 together with bus code 1, are unsupported. In these cases `cfgErr` is 1, and both `inReady` and `outValid` stay 0.
- R8: A word whose mask selects nothing to send is consumed with no output beat, and `inReady` returns the next cycle.
- R9: While `outValid` is 1 and `outReady` is 0 (and no clear), `outValid` and `outData` hold their values into the next cycle.
- R10: `inReady` is 0 while any beat of the held word is pending. A word taken at one clock edge shows its first beat after that edge.
- R11: While `fifoClear` is 1, `inReady` is 0. At the clock edge the held word and its remaining beats are dropped, so `outValid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordLen | input | 2 | Source word layout code (0: packed RGB565, 3: one 24-bit colour per word) |
| busWidth | input | 2 | Panel bus code (0: 16, 1: 8, 2: 18, 3: 24 bits) |
| byteMask | input | 4 | Byte-valid mask for each input word |
| reduce18 | input | 1 | Keep the low 6 bits of each 8-bit colour lane |
| fifoClear | input | 1 | Synchronous discard of the held word |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Input word accepted this cycle when both are high |
| inWord | input | 32 | Input memory word |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream takes the beat |
| outData | output | 24 | Formatted pixel or byte beat |
| cfgErr | output | 1 | Unsupported setting |

## Verification
The hardest case to reach is a clear that arrives partway through a word. The word must still have beats pending, and the downstream must be stalling. An 8-bit bus is the most useful setting here, because each word then has four beats. The stimulus drives a random `outReady` and schedules the clear for a chosen cycle of the phase. Words are pushed at random gaps, so the clear lands on held words in different states of progress. A behavioural model holds the pending beats in a queue and compares handshakes and data in every cycle. The error settings are checked by offering words and observing that none are taken.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int SLOT_W = 2;

  localparam logic [1:0] WL_PACKED16 = 2'd0;
  localparam logic [1:0] WL_WORD32   = 2'd3;

  localparam logic [1:0] BUS_16 = 2'd0;
  localparam logic [1:0] BUS_8  = 2'd1;
  localparam logic [1:0] BUS_18 = 2'd2;
  localparam logic [1:0] BUS_24 = 2'd3;

  typedef struct packed {
    logic              load;
    logic              advance;
    logic              clear;
    logic [SLOT_W-1:0] slot;
  } unpackStrobes_t;
endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import pix_unpack_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       wordLen,
  input  logic [1:0]       busWidth,
  input  logic [NBYTES-1:0] byteMask,
  input  logic             fifoClear,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             cfgErr,
  output unpackStrobes_t   strb
);
  localparam int NHALF = NBYTES / 2;

  logic [NBYTES-1:0] pending;
  logic [NBYTES-1:0] freshSlots;
  logic [NBYTES-1:0] lowBit;
  logic [SLOT_W-1:0] slotIdx;
  logic              busy;

  assign cfgErr = (wordLen == 2'd1) || (wordLen == 2'd2) ||
                  ((wordLen == WL_WORD32) && (busWidth == BUS_8));

  always_comb begin
    freshSlots = '0;
    if (wordLen == WL_WORD32) begin
      freshSlots[0] = 1'b1;
    end else if (busWidth == BUS_8) begin
      freshSlots = byteMask;
    end else begin
      for (int k = 0; k < NHALF; k++) begin
        freshSlots[2*k] = byteMask[2*k] & byteMask[2*k+1];
      end
    end
  end

  assign busy     = |pending;
  assign lowBit   = pending & (~pending + 1'b1);
  assign inReady  = !busy && !cfgErr && !fifoClear;
  assign outValid = busy && !cfgErr;

  always_comb begin
    slotIdx = '0;
    for (int i = NBYTES - 1; i >= 0; i--) begin
      if (pending[i]) slotIdx = i[SLOT_W-1:0];
    end
  end

  assign strb.load    = inValid && inReady;
  assign strb.advance = outValid && outReady;
  assign strb.clear   = fifoClear;
  assign strb.slot    = slotIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strb.clear) begin
      pending <= '0;
    end else if (strb.load) begin
      pending <= freshSlots;
    end else if (strb.advance) begin
      pending <= pending & ~lowBit;
    end
  end

  AST_NO_INTAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!outValid && !inReady)); // R7
  AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> !outValid); // R11
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !fifoClear) |=> outValid); // R9
  AST_ONE_BEAT_PER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear) |=> ($countones(pending) == $countones($past(pending)) - 1)); // R10
endmodule

// File: rtl/unpack_dp.sv
module unpack_dp
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  unpackStrobes_t    strb,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        busWidth,
  input  logic [3:0]        byteMask,
  input  logic              reduce18,
  output logic [BUS_W-1:0]  outData
);
  logic [WORD_W-1:0] wordQ;
  logic [7:0]        byteSel;
  logic [15:0]       halfSel;
  logic [4:0]        red5, blue5;
  logic [5:0]        green6;
  logic [23:0]       wide24, reduced, chosen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strb.load) begin
      wordQ <= inWord;
    end
  end

  assign byteSel = wordQ[{strb.slot, 3'b000} +: 8];
  assign halfSel = strb.slot[1] ? wordQ[31:16] : wordQ[15:0];
  assign red5    = halfSel[15:11];
  assign green6  = halfSel[10:5];
  assign blue5   = halfSel[4:0];

  assign wide24  = {wordQ[23:16] & {8{byteMask[2]}},
                    wordQ[15:8]  & {8{byteMask[1]}},
                    wordQ[7:0]   & {8{byteMask[0]}}};
  assign reduced = {6'b0, wide24[21:16], wide24[13:8], wide24[5:0]};
  assign chosen  = reduce18 ? reduced : wide24;

  always_comb begin
    outData = '0;
    if (wordLen == WL_PACKED16) begin
      case (busWidth)
        BUS_8:   outData = {16'b0, byteSel};
        BUS_16:  outData = {8'b0, halfSel};
        BUS_18:  outData = {6'b0, red5, 1'b0, green6, blue5, 1'b0};
        default: outData = {red5, 3'b0, green6, 2'b0, blue5, 3'b0};
      endcase
    end else begin
      case (busWidth)
        BUS_16:  outData = {8'b0, chosen[15:0]};
        BUS_18:  outData = {6'b0, chosen[17:0]};
        default: outData = chosen;
      endcase
    end
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        busWidth,
  input  logic [3:0]        byteMask,
  input  logic              reduce18,
  input  logic              fifoClear,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  input  logic              outReady,
  output logic [BUS_W-1:0]  outData,
  output logic              cfgErr
);
  localparam int NBYTES = WORD_W / 8;

  unpackStrobes_t strb;

  unpack_ctrl #(.NBYTES(NBYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .wordLen(wordLen), .busWidth(busWidth),
    .byteMask(byteMask), .fifoClear(fifoClear), .inValid(inValid),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .cfgErr(cfgErr), .strb(strb)
  );

  unpack_dp #(.WORD_W(WORD_W), .BUS_W(BUS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord),
    .wordLen(wordLen), .busWidth(busWidth), .byteMask(byteMask),
    .reduce18(reduce18), .outData(outData)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !fifoClear) |=> $stable(outData)); // R9
endmodule

// File: tb/tb_pixel_unpacker.sv
module tb_pixel_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  wordLen = 2'd0;
  logic [1:0]  busWidth = 2'd0;
  logic [3:0]  byteMask = 4'hF;
  logic        reduce18 = 1'b0;
  logic        fifoClear = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outReady = 1'b0;
  logic        inReady, outValid, cfgErr;
  logic [23:0] outData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [23:0] held[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_unpacker dut (
    .clk(clk), .rstN(rstN), .wordLen(wordLen), .busWidth(busWidth),
    .byteMask(byteMask), .reduce18(reduce18), .fifoClear(fifoClear),
    .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outData(outData), .cfgErr(cfgErr)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit expectErr();
    return (wordLen == 2'd1) || (wordLen == 2'd2) || (wordLen == 2'd3 && busWidth == 2'd1);
  endfunction

  function automatic string dataTag();
    if (wordLen == 2'd0) begin
      if (busWidth == 2'd0) return "R2";
      if (busWidth == 2'd1) return "R3";
      return "R4";
    end
    if (reduce18 || busWidth != 2'd3) return "R6";
    return "R5";
  endfunction

  task automatic pushPixels(logic [31:0] w);
    int p;
    if (wordLen == 2'd0) begin
      if (busWidth == 2'd1) begin
        for (int i = 0; i < 4; i++)
          if (byteMask[i]) held.push_back(24'((w >> (8*i)) & 32'hFF));
      end else begin
        for (int k = 0; k < 2; k++) begin
          if (byteMask[2*k] && byteMask[2*k+1]) begin
            int h, r, g, b;
            h = int'((w >> (16*k)) & 32'hFFFF);
            r = (h >> 11) & 31; g = (h >> 5) & 63; b = h & 31;
            case (busWidth)
              2'd0: p = h;
              2'd2: p = (r << 13) | (g << 6) | (b << 1);
              default: p = (r << 19) | (g << 10) | (b << 3);
            endcase
            held.push_back(24'(p));
          end
        end
      end
    end else begin
      p = 0;
      for (int i = 0; i < 3; i++)
        if (byteMask[i]) p = p | int'(w & (32'hFF << (8*i)));
      if (reduce18)
        p = (((p >> 16) & 63) << 12) | (((p >> 8) & 63) << 6) | (p & 63);
      if (busWidth == 2'd0) p = p & 'hFFFF;
      else if (busWidth == 2'd2) p = p & 'h3FFFF;
      held.push_back(24'(p));
    end
  endtask

  task automatic runPhase(int nWords, int readyPct, int clearAt, string ctlTag);
    int sent = 0;
    int cyc = 0;
    bit haveWord = 0;
    logic [31:0] w = '0;
    bit eErr, eOV, eIR;
    while (cyc < 3000) begin
      if (sent >= nWords && held.size() == 0) break;
      if (expectErr() && cyc >= 30) break;
      @(negedge clk);
      if (!haveWord) begin w = $urandom; haveWord = 1; end
      inValid   = (sent < nWords) && ($urandom % 4 != 0);
      inWord    = w;
      outReady  = ($urandom % 100) < readyPct;
      fifoClear = (cyc == clearAt);
      #1;
      eErr = expectErr();
      eOV  = (held.size() > 0) && !eErr;
      eIR  = (held.size() == 0) && !eErr && !fifoClear;
      check(cfgErr == eErr, "R7", "cfgErr", cfgErr, eErr);
      check(outValid == eOV, ctlTag, "outValid", outValid, eOV);
      check(inReady == eIR, ctlTag, "inReady", inReady, eIR);
      if (eOV && outValid) check(outData == held[0], dataTag(), "outData", outData, held[0]);
      if (fifoClear) begin
        held.delete();
      end else begin
        if (eOV && outReady) void'(held.pop_front());
        if (inValid && eIR) begin pushPixels(w); sent++; haveWord = 0; end
      end
      cyc++;
    end
    @(negedge clk);
    inValid = 0; fifoClear = 0; outReady = 0;
  endtask

  task automatic setCfg(logic [1:0] wl, logic [1:0] bw, logic [3:0] m, logic rd);
    @(negedge clk);
    wordLen = wl; busWidth = bw; byteMask = m; reduce18 = rd;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      mismatched++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);

    runPhase(20, 70, -1, "R10");             // R2 packed halves on 16-bit bus
    setCfg(2'd0, 2'd1, 4'hF, 0); runPhase(12, 60, -1, "R10"); // R3 byte beats
    setCfg(2'd0, 2'd1, 4'h5, 0); runPhase(8, 80, -1, "R10");  // R3 sparse mask
    setCfg(2'd0, 2'd2, 4'hF, 0); runPhase(10, 70, -1, "R10"); // R4 18-bit
    setCfg(2'd0, 2'd3, 4'hF, 0); runPhase(10, 70, -1, "R10"); // R4 24-bit
    setCfg(2'd0, 2'd0, 4'h3, 0); runPhase(8, 90, -1, "R10");  // R2 low half only
    setCfg(2'd0, 2'd0, 4'hC, 0); runPhase(8, 90, -1, "R10");  // R2 high half only
    setCfg(2'd0, 2'd0, 4'h0, 0); runPhase(8, 90, -1, "R8");   // R8 nothing to send
    setCfg(2'd0, 2'd1, 4'hF, 0); runPhase(10, 20, -1, "R9");  // R9 heavy stall
    setCfg(2'd0, 2'd1, 4'hF, 0); runPhase(6, 30, 7, "R11");   // R11 clear mid-word
    setCfg(2'd3, 2'd3, 4'h7, 0); runPhase(10, 70, -1, "R10"); // R5
    setCfg(2'd3, 2'd3, 4'hF, 0); runPhase(6, 70, -1, "R10");  // R5 top byte ignored
    setCfg(2'd3, 2'd3, 4'h5, 0); runPhase(6, 70, -1, "R10");  // R5 masked byte
    setCfg(2'd3, 2'd3, 4'h7, 0); runPhase(5, 20, 4, "R11");   // R11 clear on held pixel
    setCfg(2'd3, 2'd2, 4'h7, 1); runPhase(10, 70, -1, "R10"); // R6 reduce on 18-bit
    setCfg(2'd3, 2'd3, 4'h7, 1); runPhase(6, 70, -1, "R10");  // R6 reduce on 24-bit
    setCfg(2'd3, 2'd0, 4'h7, 0); runPhase(6, 70, -1, "R10");  // R6 16-bit bus limit
    setCfg(2'd3, 2'd2, 4'h7, 0); runPhase(6, 70, -1, "R10");  // R6 18-bit bus limit
    setCfg(2'd3, 2'd1, 4'h7, 0); runPhase(5, 90, -1, "R7");   // R7 32-bit on 8-bit bus
    setCfg(2'd1, 2'd0, 4'hF, 0); runPhase(5, 90, -1, "R7");   // R7 reserved length code
    setCfg(2'd0, 2'd0, 4'hF, 0); runPhase(6, 90, -1, "R10");  // recovery

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule